// File: doc/BRIEF.md
# Indexed Colour Palette Port

This block is a register-mapped colour lookup table for a pixel display pipeline. It holds 256 normal palette entries and a small overlay bank of 4 entries for cursor colours. Each entry has an 8-bit red, green and blue component. The host reaches the table through a 32-bit word interface. It first loads an entry number into the index register. It then moves the three components one at a time through a data word, always with red first, then green, then blue. After blue, the index steps on to the next entry, so a whole palette can be loaded with one index write followed by a stream of data writes.

The overlay bank appears through its own data offset. That offset uses the low bits of the same index and the same component sequence. A second port, independent of the host side, is used by the display pipeline. It takes a 9-bit entry number and returns the packed 24-bit colour one clock later. Control words at other offsets are accepted and dropped.

Top module: `clut_port`

## Requirements
- R1: A full-word write at offset 0 loads the index from data bits 31:24 and returns the component phase to red. The other data bits are ignored.
- R2: Full-word writes at offset 4 store data bits 31:24 into the red, green and blue components of the indexed normal entry, in that order, one component per write.
- R3: The access that handles blue increments the index modulo 256 and returns the phase to red. An index of 255 wraps to 0.
- R4: Data accesses at offset 12 target overlay entry 256 + index[1:0]. They follow the same phase sequence and increment the full index after blue.
- R5: A full-word read at offset 4 or 12 returns the current component in bus_rdata bits 31:24, with bits 23:0 zero, on the cycle after the access. It advances the phase and index exactly as a write does.
- R6: After reset, every entry is zero except entries 255, 256 and 258, which read 0xFFFFFF. The index is 0 and the phase is red.
- R7: An access with bus_be other than 4'hF is ignored. A write at any offset other than 0, 4 and 12 is also ignored. Neither changes any entry, the index or the phase.
- R8: A read at any offset other than 4 and 12 returns zero and leaves the index and phase unchanged. bus_rdata is zero on any cycle that does not follow a data read.
- R9: lk_rgb presents {R,G,B} of lk_entry (R in bits 23:16) one cycle after lk_entry is applied. A component written in the same cycle as a lookup shows on the lookup made in the following cycle.
- R10: A lookup of entry 260 or above returns zero.
- R11: An index write in the middle of a sequence restarts at red. Components already written keep their values, and the components not yet written keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; only 4'hF makes a valid access |
| bus_addr | input | 4 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| lk_entry | input | 9 | Entry number for the display lookup |
| lk_rgb | output | 24 | Registered {R,G,B} of the looked-up entry |

## Verification
A phase or index that has slipped never shows by itself. It appears only when a later data access lands in the wrong component or entry. The bench therefore follows every write burst with lookups of the target entry and of its neighbours, and it checks read-back bursts component by component on the very next cycle. Ignored and partial accesses are each followed by a data access whose landing place shows whether the phase or index moved. Off-by-one slips at the wrap point and the overlay base are checked one lookup cycle after the write that would have caused them.

// File: rtl/clut_pkg.sv
package clut_pkg;
   typedef enum logic [1:0] {
      PH_R = 2'd0,
      PH_G = 2'd1,
      PH_B = 2'd2
   } phase_e;

   // packed slot of a component inside {R,G,B}: red is the top slot
   function automatic logic [1:0] slot_of(phase_e p);
      return 2'd2 - 2'(p);
   endfunction
endpackage

// File: rtl/clut_seq.sv
module clut_seq
   import clut_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic             step,
   output logic [IDX_W-1:0] idx_q,
   output phase_e           ph_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         ph_q  <= PH_R;
      end else if (ld) begin
         idx_q <= ld_idx;
         ph_q  <= PH_R;
      end else if (step) begin
         unique case (ph_q)
            PH_R:    ph_q <= PH_G;
            PH_G:    ph_q <= PH_B;
            default: begin
               ph_q  <= PH_R;
               idx_q <= idx_q + 1'b1;
            end
         endcase
      end
   end

   // R1
   idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (ph_q == PH_R) && (idx_q == $past(ld_idx)));

   // R3
   blue_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld && ph_q == PH_B) |=> (ph_q == PH_R) && (idx_q == IDX_W'($past(idx_q) + 1'b1)));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !step) |=> $stable(idx_q) && $stable(ph_q));
endmodule

// File: rtl/clut_store.sv
module clut_store #(
   parameter int NUM_NORMAL = 256,
   parameter int NUM_OVL    = 4,
   parameter int COMP_W     = 8,
   parameter int ENT_W      = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ENT_W-1:0]    wr_ent,
   input  logic [1:0]          wr_slot,
   input  logic [COMP_W-1:0]   wr_val,
   input  logic [ENT_W-1:0]    rd_ent,
   input  logic [1:0]          rd_slot,
   output logic [COMP_W-1:0]   rd_val,
   input  logic [ENT_W-1:0]    lk_ent,
   output logic [3*COMP_W-1:0] lk_rgb_q
);
   localparam int NUM_ENT = NUM_NORMAL + NUM_OVL;
   localparam logic [ENT_W-1:0] ENT_LIM = ENT_W'(NUM_ENT);

   logic [2:0][COMP_W-1:0] ent_q [NUM_ENT];

   for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      localparam bit WHITE = (e == NUM_NORMAL - 1) || (e == NUM_NORMAL) ||
                             (e == NUM_NORMAL + 2);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q[e] <= WHITE ? '1 : '0;
         else if (wr_en && wr_ent == ENT_W'(e))
            ent_q[e][wr_slot] <= wr_val;
      end
   end

   always_comb begin
      rd_val = '0;
      if (rd_ent < ENT_LIM && rd_slot != 2'd3)
         rd_val = ent_q[rd_ent][rd_slot];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lk_rgb_q <= '0;
      else if (lk_ent < ENT_LIM)
         lk_rgb_q <= ent_q[lk_ent];
      else
         lk_rgb_q <= '0;
   end

   // R10
   lk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_ent >= ENT_LIM) |=> (lk_rgb_q == '0));

   // R2
   wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_slot != 2'd3) && (wr_ent < ENT_LIM));
endmodule

// File: rtl/clut_port.sv
module clut_port
   import clut_pkg::*;
#(
   parameter  int NUM_NORMAL = 256,
   parameter  int NUM_OVL    = 4,
   parameter  int COMP_W     = 8,
   parameter  int DATA_W     = 32,
   parameter  int ADDR_W     = 4,
   localparam int ENT_W      = $clog2(NUM_NORMAL + NUM_OVL + 1),
   localparam int BE_W       = DATA_W / 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [BE_W-1:0]     bus_be,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [ENT_W-1:0]    lk_entry,
   output logic [3*COMP_W-1:0] lk_rgb
);
   localparam int IDX_W = $clog2(NUM_NORMAL);
   localparam int OVL_W = $clog2(NUM_OVL);
   localparam logic [ADDR_W-1:0] OFS_IDX = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFS_DAT = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] OFS_OVL = ADDR_W'(12);

   if (NUM_NORMAL < 2 || (1 << IDX_W) != NUM_NORMAL) begin : g_bad_norm
      $error("NUM_NORMAL must be a power of two");
   end
   if (NUM_OVL < 2 || (1 << OVL_W) != NUM_OVL || NUM_OVL > NUM_NORMAL) begin : g_bad_ovl
      $error("NUM_OVL must be a power of two between 2 and NUM_NORMAL");
   end
   if (DATA_W % 8 != 0 || DATA_W < COMP_W || DATA_W < IDX_W || ADDR_W < 4) begin : g_bad_bus
      $error("bus widths do not fit the component and index fields");
   end

   logic             acc, idx_wr, dat_acc, ovl_sel;
   logic [IDX_W-1:0] idx_q;
   phase_e           ph_q;
   logic [ENT_W-1:0] cur_ent;
   logic [1:0]       cur_slot;
   logic [COMP_W-1:0] rd_val;
   logic             unused_wdata;

   assign acc      = bus_sel && (bus_be == '1);
   assign idx_wr   = acc && bus_we && (bus_addr == OFS_IDX);
   assign ovl_sel  = (bus_addr == OFS_OVL);
   assign dat_acc  = acc && ((bus_addr == OFS_DAT) || ovl_sel);
   assign cur_slot = slot_of(ph_q);
   assign unused_wdata = ^bus_wdata[DATA_W-COMP_W-1:0];

   if (IDX_W > OVL_W) begin : g_ovl_map
      assign cur_ent = ovl_sel ? ENT_W'(NUM_NORMAL) + ENT_W'(idx_q[OVL_W-1:0])
                               : ENT_W'(idx_q);
   end else begin : g_ovl_full
      assign cur_ent = ovl_sel ? ENT_W'(NUM_NORMAL) + ENT_W'(idx_q) : ENT_W'(idx_q);
   end

   clut_seq #(.IDX_W(IDX_W)) seq_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (idx_wr),
      .ld_idx (bus_wdata[DATA_W-1 -: IDX_W]),
      .step   (dat_acc),
      .idx_q  (idx_q),
      .ph_q   (ph_q)
   );

   clut_store #(
      .NUM_NORMAL (NUM_NORMAL),
      .NUM_OVL    (NUM_OVL),
      .COMP_W     (COMP_W),
      .ENT_W      (ENT_W)
   ) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (dat_acc && bus_we),
      .wr_ent   (cur_ent),
      .wr_slot  (cur_slot),
      .wr_val   (bus_wdata[DATA_W-1 -: COMP_W]),
      .rd_ent   (cur_ent),
      .rd_slot  (cur_slot),
      .rd_val   (rd_val),
      .lk_ent   (lk_entry),
      .lk_rgb_q (lk_rgb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (dat_acc && !bus_we)
         bus_rdata <= {rd_val, {(DATA_W-COMP_W){1'b0}}};
      else
         bus_rdata <= '0;
   end

   // R8
   rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dat_acc && !bus_we) |=> (bus_rdata == '0));

   // R5
   rdata_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_acc && !bus_we) |=> (bus_rdata[DATA_W-COMP_W-1:0] == '0));

   // R4
   ovl_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_acc && ovl_sel) |-> (cur_ent >= ENT_W'(NUM_NORMAL)) &&
                               (cur_ent < ENT_W'(NUM_NORMAL + NUM_OVL)));
endmodule

// File: tb/clut_port_tb_top.sv
module clut_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_be = 4'hF;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [8:0]  lk_entry = '0;
   logic [23:0] lk_rgb;

   int nchk = 0, nfail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   clut_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .lk_entry(lk_entry), .lk_rgb(lk_rgb)
   );

   // vector: {we, addr[3:0], value[7:0]}; value is write data or expected read
   localparam int NV = 16;
   localparam logic [12:0] VEC [NV] = '{
      {1'b1, 4'd0,  8'h0A}, {1'b1, 4'd4,  8'h11}, {1'b1, 4'd4,  8'h12},
      {1'b1, 4'd4,  8'h13}, {1'b1, 4'd0,  8'h0A}, {1'b0, 4'd4,  8'h11},
      {1'b0, 4'd4,  8'h12}, {1'b0, 4'd4,  8'h13}, {1'b1, 4'd0,  8'h05},
      {1'b1, 4'd12, 8'hA1}, {1'b1, 4'd12, 8'hA2}, {1'b1, 4'd12, 8'hA3},
      {1'b1, 4'd0,  8'h01}, {1'b0, 4'd12, 8'hA1}, {1'b0, 4'd12, 8'hA2},
      {1'b0, 4'd12, 8'hA3}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic bus_op(input logic we, input logic [3:0] a, input logic [31:0] d,
                         input logic [3:0] be, output logic [31:0] rd);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      rd = bus_rdata;
      bus_sel = 1'b0; bus_be = 4'hF;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] v);
      logic [31:0] rd;
      bus_op(1'b1, a, {v, 24'h0}, 4'hF, rd);
   endtask

   task automatic look(input logic [8:0] e, output logic [23:0] rgb);
      @(negedge clk);
      lk_entry = e;
      @(negedge clk);
      rgb = lk_rgb;
   endtask

   task automatic chk_ent(input string tag, input logic [8:0] e, input logic [23:0] exp);
      logic [23:0] rgb;
      look(e, rgb);
      chk(tag, {8'h0, rgb}, {8'h0, exp});
   endtask

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R6 reset contents
      chk_ent("R6 entry255", 9'd255, 24'hFFFFFF);
      chk_ent("R6 entry256", 9'd256, 24'hFFFFFF);
      chk_ent("R6 entry258", 9'd258, 24'hFFFFFF);
      chk_ent("R6 entry257", 9'd257, 24'h000000);
      chk_ent("R6 entry259", 9'd259, 24'h000000);
      chk_ent("R6 entry254", 9'd254, 24'h000000);
      chk("R6 rdata idle", bus_rdata, 32'h0);
      // R6 index 0 and phase red: first data write lands in red of entry 0
      wr(4'd4, 8'h3C);
      chk_ent("R6 index phase", 9'd0, 24'h3C0000);

      // table walk: bursts over normal and overlay entries (R2 R4 R5)
      for (int i = 0; i < NV; i++) begin
         bus_op(VEC[i][12], VEC[i][11:8], {VEC[i][7:0], 24'h0}, 4'hF, rd);
         if (!VEC[i][12])
            chk($sformatf("R5 vector %0d", i), rd, {VEC[i][7:0], 24'h0});
      end
      chk_ent("R2 entry10", 9'd10, 24'h111213);
      chk_ent("R4 entry257", 9'd257, 24'hA1A2A3);
      chk_ent("R4 entry5 untouched", 9'd5, 24'h000000);
      // R4 index after overlay read burst is 2
      wr(4'd4, 8'h5A);
      chk_ent("R4 increment", 9'd2, 24'h5A0000);

      // R1 index from top byte, low bits ignored
      bus_op(1'b1, 4'd0, 32'h80FF_FFFF, 4'hF, rd);
      wr(4'd4, 8'h77);
      chk_ent("R1 index load", 9'd128, 24'h770000);

      // R3 wrap 255 -> 0
      wr(4'd0, 8'hFF);
      wr(4'd4, 8'h01); wr(4'd4, 8'h02); wr(4'd4, 8'h03);
      wr(4'd4, 8'h44);
      chk_ent("R3 entry255", 9'd255, 24'h010203);
      chk_ent("R3 wrap entry0", 9'd0, 24'h440000);

      // R8 reads elsewhere return zero and keep phase
      wr(4'd0, 8'h0A);
      bus_op(1'b0, 4'd8, 32'h0, 4'hF, rd);
      chk("R8 read ofs8", rd, 32'h0);
      bus_op(1'b0, 4'd0, 32'h0, 4'hF, rd);
      chk("R8 read ofs0", rd, 32'h0);
      bus_op(1'b0, 4'd4, 32'h0, 4'hF, rd);
      chk("R8 phase kept", rd, 32'h1100_0000);

      // R7 ignored writes
      wr(4'd0, 8'd30);
      wr(4'd8, 8'hAA);
      bus_op(1'b1, 4'd4, 32'hBB00_0000, 4'h3, rd);
      wr(4'd4, 8'h12);
      bus_op(1'b1, 4'd0, 32'h6300_0000, 4'hC, rd);
      wr(4'd4, 8'h34);
      chk_ent("R7 ignored accesses", 9'd30, 24'h123400);
      chk_ent("R7 entry99 untouched", 9'd99, 24'h000000);

      // R11 partial sequence then index write
      wr(4'd0, 8'd20);
      wr(4'd4, 8'h55); wr(4'd4, 8'h66);
      wr(4'd0, 8'd21);
      wr(4'd4, 8'h99);
      chk_ent("R11 entry20", 9'd20, 24'h556600);
      chk_ent("R11 entry21", 9'd21, 24'h990000);

      // R9 write and lookup in the same cycle
      wr(4'd0, 8'd40);
      wr(4'd4, 8'hC1); wr(4'd4, 8'hC2);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd4; bus_wdata = 32'h3300_0000;
      lk_entry = 9'd40;
      @(negedge clk);
      bus_sel = 1'b0;
      chk("R9 same-cycle old", {8'h0, lk_rgb}, 32'h00C1C200);
      @(negedge clk);
      chk("R9 next lookup", {8'h0, lk_rgb}, 32'h00C1C233);

      // R10 out-of-range lookups
      chk_ent("R10 entry260", 9'd260, 24'h0);
      chk_ent("R10 entry511", 9'd511, 24'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog act=running exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end
endmodule